// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block translates 32-bit virtual addresses through a small, fully associative table. Each slot describes a pair of adjacent virtual pages that share one tag. A per-slot size field sets the page size, from 4 KiB up to 16 MiB. The two pages of a pair carry separate frame numbers and separate permission bits. A tag can be tied to one 8-bit address-space identifier, or it can be marked global so that it matches in every address space.

A lookup presents an address, the current address-space identifier and a flag that is set for stores. One clock later the block returns either a physical address or a fault code. The fault codes are no mapping, page not valid, and write to a clean page. With a fault it also returns two values for the fault handler: the faulting address, and an entry-tag value built from that address and the current identifier. Slots are loaded through a synchronous write port that takes a slot number.

Top module: `tlb_pair_lookup`

## Requirements
- R1: After reset, every slot is empty, `rsp_valid` is 0 and `rsp_fault` is 0. Any lookup then returns fault code 1 (no mapping).
- R2: A write with `wr_en` high stores the four words in slot `wr_idx` at the clock edge. A lookup issued in the same cycle as a write still sees the slot's earlier contents.
- R3: Bits 24..13 of the size word give the page mask. A tag matches when the address and the tag bits 31..0 are equal at every position outside the page mask and outside bits 12..0.
- R4: A slot matches only if the tag's bits 7..0 equal `lk_asid`, or the tag's global bit (bit 12) is 1.
- R5: The page-offset mask is the page mask shifted right by one, ORed with 0xFFF. The address bit just above that offset picks the pair's first frame word when it is 0 and the second frame word when it is 1.
- R6: If the chosen frame word has its valid bit (bit 1) clear, the result is fault code 2. This applies to loads and stores alike.
- R7: On a store, if the chosen frame word is valid but its dirty bit (bit 2) is clear, the result is fault code 3. A load never produces code 3.
- R8: Without a fault, `rsp_paddr` equals (frame word AND 0x03FFFFC0) shifted left by 6, with the offset positions cleared, ORed with the address bits at the offset positions.
- R9: If no slot matches, the result is fault code 1. This applies to loads and stores alike.
- R10: On any fault, `rsp_badvaddr` holds the looked-up address and `rsp_entryhi` holds {address bits 31..13, five zeros, `lk_asid`}, while `rsp_paddr` is 0. Without a fault, both `rsp_badvaddr` and `rsp_entryhi` are 0.
- R11: If several slots match, the lowest-numbered slot decides the result.
- R12: The result appears one cycle after `lk_valid`. `rsp_valid` follows `lk_valid` and `rsp_store` repeats the store flag. While `rsp_valid` is 0, `rsp_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W | Slot number to write |
| wr_mask | input | 32 | Page size word (mask in bits 24..13) |
| wr_hi | input | 32 | Tag word: bits 31..13 page-pair number, bit 12 global, bits 7..0 identifier |
| wr_lo0 | input | 32 | First frame word: bits 25..6 frame, bit 2 dirty, bit 1 valid |
| wr_lo1 | input | 32 | Second frame word, same layout |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| lk_store | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 2 | 0 none, 1 no mapping, 2 not valid, 3 clean page written |
| rsp_store | output | 1 | Store flag of the result |
| rsp_paddr | output | 32 | Physical address |
| rsp_badvaddr | output | 32 | Faulting address |
| rsp_entryhi | output | 32 | Tag value for the fault handler |

## Verification
Assertions hold on every cycle for several rules. The result follows the request by one cycle. The store flag is returned unchanged. A write to a clean page can only fault on a store. On a fault the side outputs carry the request address and identifier and the physical address is zero. On a hit the low twelve address bits pass through unchanged.

The remaining rules depend on what the table holds, and only the bench's sweeps can show them. These are the even/odd choice at each page size, the frame substitution above the offset, the identifier and global matching, the lowest-slot priority between overlapping slots, and the old-contents result of a write and a lookup issued in the same cycle.

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_mask,
  input  logic [31:0]      wr_hi,
  input  logic [31:0]      wr_lo0,
  input  logic [31:0]      wr_lo1,
  input  logic             lk_valid,
  input  logic [31:0]      lk_vaddr,
  input  logic [7:0]       lk_asid,
  input  logic             lk_store,
  output logic             rsp_valid,
  output logic [1:0]       rsp_fault,
  output logic             rsp_store,
  output logic [31:0]      rsp_paddr,
  output logic [31:0]      rsp_badvaddr,
  output logic [31:0]      rsp_entryhi
);
  localparam logic [31:0] SIZE_BITS = 32'h01FF_E000;
  localparam logic [31:0] LOW_BITS  = 32'h0000_1FFF;
  localparam logic [31:0] PFN_BITS  = 32'h03FF_FFC0;
  localparam logic [1:0]  F_NONE = 2'd0, F_MISS = 2'd1, F_INVAL = 2'd2, F_CLEAN = 2'd3;

  logic [31:0] t_mask [ENTRIES];
  logic [31:0] t_hi   [ENTRIES];
  logic [31:0] t_lo0  [ENTRIES];
  logic [31:0] t_lo1  [ENTRIES];
  logic [ENTRIES-1:0] t_used;
  logic [ENTRIES-1:0] hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) t_used <= '0;
    else if (wr_en) t_used[wr_idx] <= 1'b1;

  always_ff @(posedge clk)
    if (wr_en) begin
      t_mask[wr_idx] <= wr_mask;
      t_hi[wr_idx]   <= wr_hi;
      t_lo0[wr_idx]  <= wr_lo0;
      t_lo1[wr_idx]  <= wr_lo1;
    end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [31:0] keep;
    assign keep   = ~((t_mask[g] & SIZE_BITS) | LOW_BITS);
    assign hit[g] = t_used[g] && (((lk_vaddr ^ t_hi[g]) & keep) == 32'd0)
                    && (t_hi[g][7:0] == lk_asid || t_hi[g][12]);
  end

  logic [IDX_W-1:0] win;
  always_comb begin
    win = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit[i]) win = IDX_W'(i);
  end

  logic [31:0] off, lo, pa;
  logic        odd;
  logic [1:0]  fault;
  assign off = ((t_mask[win] & SIZE_BITS) >> 1) | 32'h0000_0FFF;
  assign odd = |(lk_vaddr & (off + 32'd1));
  assign lo  = odd ? t_lo1[win] : t_lo0[win];
  assign pa  = (((lo & PFN_BITS) << 6) & ~off) | (lk_vaddr & off);

  always_comb
    if (hit == '0)              fault = F_MISS;
    else if (!lo[1])            fault = F_INVAL;
    else if (lk_store && !lo[2]) fault = F_CLEAN;
    else                        fault = F_NONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_fault    <= F_NONE;
      rsp_store    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_badvaddr <= '0;
      rsp_entryhi  <= '0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_store    <= lk_store;
      rsp_fault    <= lk_valid ? fault : F_NONE;
      rsp_paddr    <= (fault == F_NONE) ? pa : 32'd0;
      rsp_badvaddr <= (fault != F_NONE) ? lk_vaddr : 32'd0;
      rsp_entryhi  <= (fault != F_NONE) ? {lk_vaddr[31:13], 5'd0, lk_asid} : 32'd0;
    end
endmodule

module tlb_pair_lookup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [31:0] lk_vaddr,
  input logic [7:0]  lk_asid,
  input logic        lk_store,
  input logic        rsp_valid,
  input logic [1:0]  rsp_fault,
  input logic        rsp_store,
  input logic [31:0] rsp_paddr,
  input logic [31:0] rsp_badvaddr,
  input logic [31:0] rsp_entryhi
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;

  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    rsp_valid == $past(lk_valid) && rsp_store == $past(lk_store));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_fault == 2'd0);
  assert_clean_on_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd3) |-> rsp_store);
  assert_fault_capture_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rsp_valid && rsp_fault != 2'd0) |->
      (rsp_paddr == 32'd0 && rsp_badvaddr == $past(lk_vaddr)
       && rsp_entryhi == {$past(lk_vaddr[31:13]), 5'd0, $past(lk_asid)}));
  assert_offset_pass_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rsp_valid && rsp_fault == 2'd0) |->
      (rsp_paddr[11:0] == $past(lk_vaddr[11:0]) && rsp_badvaddr == 32'd0));
endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_asid(lk_asid), .lk_store(lk_store), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_store(rsp_store), .rsp_paddr(rsp_paddr),
  .rsp_badvaddr(rsp_badvaddr), .rsp_entryhi(rsp_entryhi)
);

// File: tb/test_tlb_pair_lookup.sv
module test_tlb_pair_lookup;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [31:0] wr_mask = '0, wr_hi = '0, wr_lo0 = '0, wr_lo1 = '0;
  logic lk_valid = 1'b0, lk_store = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0] lk_asid = '0;
  logic rsp_valid, rsp_store;
  logic [1:0] rsp_fault;
  logic [31:0] rsp_paddr, rsp_badvaddr, rsp_entryhi;

  int checks = 0, fails = 0;
  logic [31:0] b_mask[N], b_hi[N], b_lo0[N], b_lo1[N];
  bit b_used[N];

  always #5ns clk = ~clk;

  tlb_pair_lookup #(.ENTRIES(N)) i_tlb_pair_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
    .wr_hi(wr_hi), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_store(lk_store),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_store(rsp_store),
    .rsp_paddr(rsp_paddr), .rsp_badvaddr(rsp_badvaddr), .rsp_entryhi(rsp_entryhi));

  task automatic predict(input logic [31:0] va, input logic [7:0] as, input logic st,
                         output logic [1:0] f, output logic [31:0] pa,
                         output logic [31:0] bv, output logic [31:0] eh);
    int w = -1;
    logic [31:0] pm, keep, off, lo;
    for (int e = 0; e < N; e++) begin
      pm = b_mask[e] & 32'h01FF_E000;
      keep = ~(pm | 32'h1FFF);
      if (w < 0 && b_used[e] && (va & keep) == (b_hi[e] & keep)
          && (b_hi[e][7:0] == as || b_hi[e][12])) w = e;
    end
    pa = 0;
    if (w < 0) f = 2'd1;
    else begin
      off = ((b_mask[w] & 32'h01FF_E000) / 2) | 32'hFFF;
      lo = ((va & (off + 1)) != 0) ? b_lo1[w] : b_lo0[w];
      if (!lo[1]) f = 2'd2;
      else if (st && !lo[2]) f = 2'd3;
      else begin
        f = 2'd0;
        pa = (((lo & 32'h03FF_FFC0) * 64) & ~off) | (va & off);
      end
    end
    bv = (f != 0) ? va : 32'd0;
    eh = (f != 0) ? {va[31:13], 5'd0, as} : 32'd0;
  endtask

  task automatic put(input int e, input logic [31:0] m, h, l0, l1);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(e); wr_mask = m; wr_hi = h; wr_lo0 = l0; wr_lo1 = l1;
    @(negedge clk);
    wr_en = 0;
    b_mask[e] = m; b_hi[e] = h; b_lo0[e] = l0; b_lo1[e] = l1; b_used[e] = 1;
  endtask

  task automatic compare(input logic [31:0] va, input logic [7:0] as, input logic st, input string tag);
    logic [1:0] f;
    logic [31:0] pa, bv, eh;
    string rq;
    predict(va, as, st, f, pa, bv, eh);
    rq = (tag != "") ? tag : (f == 0) ? "R8" : (f == 1) ? "R9" : (f == 2) ? "R6" : "R7";
    checks++;
    if (rsp_valid !== 1'b1 || rsp_store !== st || rsp_fault !== f || rsp_paddr !== pa
        || rsp_badvaddr !== bv || rsp_entryhi !== eh) begin
      fails++;
      $display("FAIL %s va=%h asid=%h st=%0d: got v=%0d s=%0d f=%0d pa=%h bv=%h eh=%h exp v=1 s=%0d f=%0d pa=%h bv=%h eh=%h",
               rq, va, as, st, rsp_valid, rsp_store, rsp_fault, rsp_paddr, rsp_badvaddr,
               rsp_entryhi, st, f, pa, bv, eh);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] as, input logic st, input string tag);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_asid = as; lk_store = st;
    @(negedge clk);
    lk_valid = 0;
    compare(va, as, st, tag);
  endtask

  function automatic logic [31:0] size_of(input int e);
    case (e % 5)
      0: return 32'h0;
      1: return 32'h6000;
      2: return 32'h1E000;
      3: return 32'h1FE000;
      default: return 32'h1FFE000;
    endcase
  endfunction

  initial begin
    logic [31:0] rnd = 32'h1357_9BDF;
    for (int e = 0; e < N; e++) b_used[e] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_fault !== 0) begin
      fails++; $display("FAIL R1 reset: got v=%0d f=%0d exp v=0 f=0", rsp_valid, rsp_fault);
    end
    rst_n = 1;
    look(32'h0000_0000, 8'h00, 0, "R1");
    look(32'h1234_5678, 8'h05, 1, "R1");

    for (int e = 0; e < 14; e++) begin
      logic [19:0] pfn0, pfn1;
      pfn0 = 20'h5A5A5 ^ 20'(e * 32'h1111);
      pfn1 = ~pfn0;
      put(e, size_of(e),
          (32'(e + 1) << 28) | 32'h0300_0000 * 0 | {19'd0, (e % 3 == 0), 4'd0, 8'(e % 4)},
          {6'd0, pfn0, 3'd0, 1'(e % 2), 2'b10},
          {6'd0, pfn1, 3'd0, 1'b1, 1'((e % 4) != 1), 1'b0});
    end
    // R11: slot 14 overlaps slot 2 (global, other frames)
    put(14, size_of(2), b_hi[2] | 32'h1000, 32'h0ABC_DE46, 32'h0123_4506);

    // R3 R4 R5 sweep across every page size, identifier and access kind
    for (int e = 0; e < 15; e++) begin
      logic [31:0] off, half, base;
      off = ((size_of(e) & 32'h01FF_E000) / 2) | 32'hFFF;
      half = off + 1;
      base = b_hi[e] & 32'hFFFF_E000;
      for (int a = 0; a < 3; a++) begin
        logic [7:0] as;
        as = (a == 0) ? 8'(e % 4) : (a == 1) ? 8'((e % 4) ^ 1) : 8'h80;
        for (int s = 0; s < 2; s++) begin
          look(base, as, 1'(s), "");
          look(base | (32'h0ABC & off), as, 1'(s), "R5");
          look(base | half, as, 1'(s), "R5");
          look(base | half | off, as, 1'(s), "R5");
          look(base + 2 * half, as, 1'(s), "R3");
          look(base ^ 32'h1000, as, 1'(s), "");
        end
      end
    end
    look(b_hi[2] & 32'hFFFF_E000, 8'h02, 0, "R11");
    look(b_hi[2] & 32'hFFFF_E000, 8'h03, 0, "R11");
    look(b_hi[3] & 32'hFFFF_E000, 8'h77, 0, "R4");

    for (int k = 0; k < 300; k++) begin
      rnd = {rnd[30:0], rnd[31] ^ rnd[21] ^ rnd[1] ^ rnd[0]};
      look({rnd[31:28], 4'd0, rnd[23:0]}, 8'(rnd[5:4]), rnd[9], "");
    end

    // R2: write and lookup in the same cycle see the old slot
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd15; wr_mask = 32'h0; wr_hi = 32'hF000_0000;
    wr_lo0 = 32'h0000_1046; wr_lo1 = 32'h0;
    lk_valid = 1; lk_vaddr = 32'hF000_0123; lk_asid = 8'h00; lk_store = 0;
    @(negedge clk);
    wr_en = 0; lk_valid = 0;
    compare(32'hF000_0123, 8'h00, 0, "R2");
    b_mask[15] = 32'h0; b_hi[15] = 32'hF000_0000; b_lo0[15] = 32'h0000_1046;
    b_lo1[15] = 32'h0; b_used[15] = 1;
    look(32'hF000_0123, 8'h00, 0, "R2");
    look(32'hF000_1123, 8'h00, 1, "R6");

    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_fault !== 0) begin
      fails++; $display("FAIL R12 idle: got v=%0d f=%0d exp v=0 f=0", rsp_valid, rsp_fault);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    fails++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule